// File: doc/BRIEF.md
# DRAM Array Model with Compressed Parallel Test Mode

This block is a small, synthesizable model of a multiplexed-address dynamic memory with a four-bit data port. Inputs are sampled on a system clock. The block watches the active-low row strobe, column strobe and write enable. A row strobe fall with the column strobe high opens a row: the address bus supplies the row. Each column strobe fall that follows selects a column and performs a read or a write. Several column strobes may fall inside one open row. Read data stays on the output after the column strobe rises, until the row strobe rises.

A row strobe fall with the column strobe already low is a refresh cycle. It opens no row. If write enable is also low at that point, the block enters a compressed test mode. In test mode the two lowest column bits are ignored, so each data line covers a group of four neighbouring columns. A write copies each data line's input bit into all four columns of the group. A read reports, per data line, whether the four stored bits agree. Test mode is left by a refresh cycle taken with write enable high, or by a row cycle that sees no column strobe at all.

The data port is split into a data input, a data output and an output-enable flag, which a pad ring can join into a bidirectional bus.

Top module: `dram_tm_top`

## Requirements
- R1: After a synchronous reset, the block is in normal mode and `dout_en` is low.
- R2: In normal mode, a column strobe fall with `we_n` low stores `din` at the word addressed by the latched row and the column on `addr`. With `we_n` high it reads that word. The read word appears on `dout` one clock after the column strobe fall is sampled.
- R3: Several column strobes within one open row each access their own column of that row.
- R4: `dout_en` is high only while read data is held and `oe_n` is low. Read data is held after the column strobe rises. `dout_en` is low in the clock after the row strobe rise is sampled.
- R5: A row strobe fall sampled with both `cas_n` and `we_n` low puts the block in test mode. The mode changes only in the clock after a row strobe edge.
- R6: In test mode, a write stores `din` into the four columns that share every column bit above bit 1. Columns outside that group keep their contents.
- R7: In test mode, a read sets `dout[b]` to 1 when bit b of the four columns in the group is all ones or all zeros, and to 0 otherwise.
- R8: A row strobe fall sampled with `cas_n` low and `we_n` high returns the block to normal mode.
- R9: A row cycle that opens a row and sees no column strobe fall before the row strobe rises returns the block to normal mode. A row cycle that has column accesses keeps the mode.
- R10: A write-enable refresh cycle taken while in test mode leaves the block in test mode.
- R11: A fall of `we_n` while the column strobe is low, after a read access has started, writes `din` at the latched column (delayed write) and drops `dout_en` in the next clock.
- R12: Refresh cycles of either kind leave the stored words unchanged and do not enable the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (4) | Multiplexed row/column address |
| din | input | 4 | Write data, one bit per data line |
| dout | output | 4 | Read data, or agreement flags in test mode |
| dout_en | output | 1 | High when `dout` should be driven onto the pins |

## Verification
The checker checks on every clock the cycles around the mode flag. A write-enable refresh always sets it and a plain refresh always clears it. The flag never moves except right after a row strobe edge. The output is never enabled once the row strobe has been high for a sampled edge, and is closed after every row strobe rise. Only the bench's scenarios can show data behaviour: that a test-mode write fills exactly a four-column group, that the agreement flags follow mixed and uniform bit patterns, that an idle row cycle exits test mode while a busy one does not, and that a delayed write replaces the word being read.

// File: rtl/dram_tm_pkg.sv
package dram_tm_pkg;

    // data port width and compressed group geometry
    localparam int DQ_W     = 4;
    localparam int GROUP    = 4;
    localparam int GRP_BITS = 2;

    typedef logic [DQ_W-1:0] word_t;

    // decoded strobe activity for one clock
    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_rise;
        logic we_fall;
        logic cas_low;
        logic we_low;
    } strobe_ev_t;

    // what the current row strobe low period is doing
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ROW     = 2'd1,
        PH_REFRESH = 2'd2
    } row_phase_e;

    // per data line: 1 when all four samples hold the same value
    function automatic word_t agree_flags(input word_t a, input word_t b,
                                          input word_t c, input word_t d);
        word_t all_one;
        word_t any_one;
        all_one = a & b & c & d;
        any_one = a | b | c | d;
        return all_one | ~any_one;
    endfunction

endpackage

// File: rtl/dram_tm_strobes.sv
module dram_tm_strobes
    import dram_tm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output strobe_ev_t ev
);

    logic ras_q;
    logic cas_q;
    logic we_q;

    // previous sampled levels; idle strobes are high
    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    always_comb begin
        ev.ras_fall = ras_q & ~ras_n;
        ev.ras_rise = ~ras_q & ras_n;
        ev.cas_fall = cas_q & ~cas_n;
        ev.cas_rise = ~cas_q & cas_n;
        ev.we_fall  = we_q & ~we_n;
        ev.cas_low  = ~cas_n;
        ev.we_low   = ~we_n;
    end

endmodule

// File: rtl/dram_tm_mode.sv
module dram_tm_mode
    import dram_tm_pkg::*;
#(
    parameter  int ROW_W  = 4,
    parameter  int COL_W  = 4,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_ev_t        ev,
    input  logic [ADDR_W-1:0] addr,
    output logic              test_q,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_sel,
    output logic              wr_en,
    output logic              rd_en,
    output logic              out_close
);

    row_phase_e       phase_q;
    logic [COL_W-1:0] col_q;
    logic             col_act_q;
    logic             cas_seen_q;
    logic             col_strobe;
    logic             late_write;
    logic             idle_row_end;

    // a column access needs a normally opened row that is still low
    assign col_strobe   = (phase_q == PH_ROW) && ev.cas_fall && !ev.ras_rise;
    assign late_write   = (phase_q == PH_ROW) && col_act_q && ev.we_fall
                          && ev.cas_low && !ev.ras_rise;
    assign idle_row_end = ev.ras_rise && (phase_q == PH_ROW) && !cas_seen_q;

    assign wr_en     = (col_strobe && ev.we_low) || late_write;
    assign rd_en     = col_strobe && !ev.we_low;
    assign col_sel   = col_strobe ? addr[COL_W-1:0] : col_q;
    assign out_close = ev.ras_rise || wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            test_q     <= 1'b0;
            row_q      <= '0;
            col_q      <= '0;
            col_act_q  <= 1'b0;
            cas_seen_q <= 1'b0;
        end else begin
            if (ev.ras_fall) begin
                cas_seen_q <= 1'b0;
                if (ev.cas_low) begin
                    // refresh cycle: write enable picks the next mode
                    phase_q <= PH_REFRESH;
                    test_q  <= ev.we_low;
                end else begin
                    phase_q <= PH_ROW;
                    row_q   <= addr[ROW_W-1:0];
                end
            end else if (ev.ras_rise) begin
                phase_q   <= PH_IDLE;
                col_act_q <= 1'b0;
                if (idle_row_end) begin
                    test_q <= 1'b0;
                end
            end else if (col_strobe) begin
                col_q      <= addr[COL_W-1:0];
                col_act_q  <= 1'b1;
                cas_seen_q <= 1'b1;
            end else if (ev.cas_rise) begin
                col_act_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dram_tm_cells.sv
module dram_tm_cells
    import dram_tm_pkg::*;
#(
    parameter  int ROW_W = 4,
    parameter  int COL_W = 4,
    localparam int IDX_W = ROW_W + COL_W,
    localparam int DEPTH = 1 << IDX_W,
    localparam int HI_W  = COL_W - GRP_BITS
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             test,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  word_t            din,
    output word_t            rd_word,
    output word_t            rd_agree
);

    word_t            mem [DEPTH];
    word_t            grp [GROUP];
    logic [HI_W-1:0]  col_hi;
    logic [GROUP-1:0] lane_we;

    assign col_hi = col[COL_W-1:GRP_BITS];

    // one write enable per column of the group
    generate
        for (genvar g = 0; g < GROUP; g++) begin : g_lane
            assign lane_we[g] = wr_en &&
                (test || (col[GRP_BITS-1:0] == GRP_BITS'(g)));
            assign grp[g] = mem[{row, col_hi, GRP_BITS'(g)}];
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int g = 0; g < GROUP; g++) begin
            if (lane_we[g]) begin
                mem[{row, col_hi, GRP_BITS'(g)}] <= din;
            end
        end
    end

    assign rd_word  = grp[col[GRP_BITS-1:0]];
    assign rd_agree = agree_flags(grp[0], grp[1], grp[2], grp[3]);

endmodule

// File: rtl/dram_tm_top.sv
module dram_tm_top
    import dram_tm_pkg::*;
#(
    parameter  int ROW_W  = 4,
    parameter  int COL_W  = 4,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   din,
    output logic [DQ_W-1:0]   dout,
    output logic              dout_en
);

    strobe_ev_t       ev;
    logic             test_mode;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_sel;
    logic             wr_en;
    logic             rd_en;
    logic             out_close;
    word_t            rd_word;
    word_t            rd_agree;
    word_t            dout_q;
    logic             rd_valid;

    dram_tm_strobes u_strobes (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ev    (ev)
    );

    dram_tm_mode #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_mode (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .addr      (addr),
        .test_q    (test_mode),
        .row_q     (row_q),
        .col_sel   (col_sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .out_close (out_close)
    );

    dram_tm_cells #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_cells (
        .clk      (clk),
        .wr_en    (wr_en),
        .test     (test_mode),
        .row      (row_q),
        .col      (col_sel),
        .din      (din),
        .rd_word  (rd_word),
        .rd_agree (rd_agree)
    );

    // output latch: held across column precharge until the row closes
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q   <= '0;
            rd_valid <= 1'b0;
        end else if (rd_en) begin
            dout_q   <= test_mode ? rd_agree : rd_word;
            rd_valid <= 1'b1;
        end else if (out_close) begin
            rd_valid <= 1'b0;
        end
    end

    assign dout    = dout_q;
    assign dout_en = rd_valid & ~oe_n;

endmodule

// File: rtl/dram_tm_chk.sv
module dram_tm_chk (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dout_en,
    input logic test_q,
    input logic rd_valid
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!test_q && !rd_valid));

    assert_enter_test_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n && !we_n) |=> test_q);

    assert_mode_at_ras_edge_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(test_q) |-> ($past(ras_n) != $past(ras_n, 2)));

    assert_exit_refresh_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n && we_n) |=> !test_q);

    assert_close_on_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |=> !dout_en);

    assert_hold_window_R4: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> !$past(ras_n));

endmodule

bind dram_tm_top dram_tm_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .dout_en  (dout_en),
    .test_q   (test_mode),
    .rd_valid (rd_valid)
);

// File: tb/dram_tm_top_bench.sv
module dram_tm_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [3:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_en;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    dram_tm_top u_dram_tm_top (
        .clk     (clk),
        .rst     (rst),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic open_row(input logic [3:0] r);
        addr = r; ras_n = 1'b0; tick();
    endtask

    task automatic close_row();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(); tick();
    endtask

    task automatic col_write(input logic [3:0] c, input logic [3:0] d);
        addr = c; din = d; we_n = 1'b0; cas_n = 1'b0; tick();
        cas_n = 1'b1; we_n = 1'b1; tick();
    endtask

    // read: result sampled one clock after the strobe fall, then strobe released
    task automatic col_read(input logic [3:0] c, output logic [3:0] d);
        addr = c; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; tick();
        d = dout;
        cas_n = 1'b1; tick();
    endtask

    task automatic write_word(input logic [3:0] r, input logic [3:0] c, input logic [3:0] d);
        open_row(r); col_write(c, d); close_row();
    endtask

    task automatic read_word(input logic [3:0] r, input logic [3:0] c, output logic [3:0] d);
        open_row(r); col_read(c, d); close_row();
    endtask

    task automatic refresh_cbr(input logic we_val);
        cas_n = 1'b0; we_n = we_val; tick();
        ras_n = 1'b0; tick(); tick();
        ras_n = 1'b1; tick();
        cas_n = 1'b1; we_n = 1'b1; tick(); tick();
    endtask

    task automatic refresh_row_only(input logic [3:0] r);
        addr = r; ras_n = 1'b0; tick(); tick();
        ras_n = 1'b1; tick(); tick();
    endtask

    task automatic t_reset();
        chk("R1 dout_en after reset", {3'b0, dout_en}, 4'h0);
        oe_n = 1'b0; #1;
        chk("R1 dout_en with oe low and no read", {3'b0, dout_en}, 4'h0);
        oe_n = 1'b1;
    endtask

    task automatic t_normal();
        logic [3:0] v;
        open_row(4'd3);
        col_write(4'd5, 4'hA);
        col_write(4'd6, 4'h5);
        close_row();
        write_word(4'd7, 4'd5, 4'hC);
        open_row(4'd3);
        col_read(4'd5, v);
        chk("R3 page read col5", v, 4'hA);
        chk("R4 data held after column strobe rise", dout, 4'hA);
        chk("R4 dout_en held after column strobe rise", {3'b0, dout_en}, 4'h1);
        oe_n = 1'b1; #1;
        chk("R4 oe_n high disables output", {3'b0, dout_en}, 4'h0);
        oe_n = 1'b0; #1;
        chk("R4 oe_n low re-enables output", {3'b0, dout_en}, 4'h1);
        col_read(4'd6, v);
        chk("R3 page read col6", v, 4'h5);
        ras_n = 1'b1; tick();
        chk("R4 dout_en low after row strobe rise", {3'b0, dout_en}, 4'h0);
        tick();
        read_word(4'd7, 4'd5, v);
        chk("R2 read other row", v, 4'hC);
        read_word(4'd3, 4'd5, v);
        chk("R2 first row unchanged by other row", v, 4'hA);
    endtask

    task automatic t_test_write();
        logic [3:0] v;
        write_word(4'd2, 4'd3, 4'hC);
        write_word(4'd2, 4'd8, 4'h3);
        refresh_cbr(1'b0);
        write_word(4'd2, 4'd6, 4'hA);
        refresh_cbr(1'b1);
        for (int c = 4; c < 8; c++) begin
            read_word(4'd2, 4'(c), v);
            chk($sformatf("R6 group column %0d (R8 normal read after exit)", c), v, 4'hA);
        end
        read_word(4'd2, 4'd3, v);
        chk("R6 column below group untouched", v, 4'hC);
        read_word(4'd2, 4'd8, v);
        chk("R6 column above group untouched", v, 4'h3);
    endtask

    task automatic t_compress();
        logic [3:0] v;
        open_row(4'd5);
        col_write(4'd8, 4'hF);
        col_write(4'd9, 4'hF);
        col_write(4'd10, 4'h7);
        col_write(4'd11, 4'hE);
        close_row();
        refresh_cbr(1'b0);
        read_word(4'd5, 4'd9, v);
        chk("R7 mixed group flags", v, 4'h6);
        read_word(4'd2, 4'd5, v);
        chk("R7 uniform group flags", v, 4'hF);
    endtask

    task automatic t_stay_and_exit();
        logic [3:0] v;
        refresh_cbr(1'b0);
        oe_n = 1'b0; #1;
        chk("R12 refresh leaves output disabled", {3'b0, dout_en}, 4'h0);
        read_word(4'd5, 4'd11, v);
        chk("R10 still compressed after repeat entry (R9 busy row keeps mode)", v, 4'h6);
        refresh_row_only(4'd0);
        read_word(4'd5, 4'd8, v);
        chk("R9 idle row cycle exits to normal read", v, 4'hF);
        read_word(4'd5, 4'd10, v);
        chk("R12 word intact after refreshes", v, 4'h7);
    endtask

    task automatic t_late_write();
        logic [3:0] v;
        write_word(4'd9, 4'd1, 4'h1);
        open_row(4'd9);
        addr = 4'd1; oe_n = 1'b0; we_n = 1'b1; cas_n = 1'b0; tick();
        chk("R11 read before late write", dout, 4'h1);
        din = 4'h9; we_n = 1'b0; tick();
        chk("R11 output closed by late write", {3'b0, dout_en}, 4'h0);
        cas_n = 1'b1; we_n = 1'b1; tick();
        close_row();
        read_word(4'd9, 4'd1, v);
        chk("R11 late write stored", v, 4'h9);
    endtask

    logic done = 1'b0;

    initial begin
        fork
            begin
                repeat (3) tick();
                rst = 1'b0;
                tick();
                t_reset();
                t_normal();
                t_test_write();
                t_compress();
                t_stay_and_exit();
                t_late_write();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule